// File: doc/BRIEF.md
# Wake-up interrupt polarity normalizer

This block sits between a bank of raw interrupt request lines and a downstream interrupt controller that understands only two kinds of input: an active-high level, or a rising edge. Each line carries its own enable bit and a 3-bit trigger code, both programmed through a small memory-mapped register port. The block synchronizes every raw line and converts it according to its code. It inverts active-low levels. It turns falling edges into a one-clock pulse, and it turns every transition of a both-edge line into a one-clock pulse. As a result the downstream side never has to deal with low-true or falling-edge signalling.

Software enables a line by reading the enable word that holds its bit, changing that one bit and writing the word back. A line that is disabled, or that holds a reserved code, keeps its output low. Its edge history keeps following the input, so enabling the line later does not produce a false event.

Top module: `wake_polarity_norm`

## Requirements
- R1: After reset, every enable bit reads 0, every trigger code reads 000, every normalized output is low and the read data is 0.
- R2: The enable bit of line n is bit n%32 of the word at byte address 0x10 + 4*(n/32). A write stores all 32 bits of that one word and leaves every other word unchanged. Bits of the last word above the highest line read 0. Setting or clearing one line through read-modify-write leaves the other bits of the word intact.
- R3: The trigger code of line n sits at byte address 0x110 + 4*n. A write stores bits 2:0 of the write data. A read returns the stored code in bits 2:0 with bits 31:3 zero. Read data is registered and is valid in the cycle after the read request.
- R4: Code 100 (active-high level): an enabled line's output follows the raw input. A change on the input shows on the output after the third rising clock edge that follows it.
- R5: Code 000 (active-low level): an enabled line's output is the inverse of the raw input, with the same latency as R4.
- R6: Code 110 (rising edge): every low-to-high input transition gives exactly one output pulse, one clock long, after the third rising clock edge. A high-to-low transition gives no pulse.
- R7: Code 010 (falling edge): every high-to-low input transition gives exactly one one-clock output pulse, with the latency of R6. A low-to-high transition gives no pulse.
- R8: Code 111 (both edges): every input transition, in either direction, gives exactly one one-clock output pulse, with the latency of R6.
- R9: A line whose enable bit is 0 drives its output low whatever its input and code are. Clearing the enable bit brings a high level output low.
- R10: The edge history of a disabled line keeps following its input. Enabling an edge-mode line whose input has been steady therefore gives no output pulse.
- R11: The reserved codes 001, 011 and 101 keep the output low even when the line is enabled, and they read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| irq_raw | input | N | Raw interrupt lines, asynchronous |
| irq_out | output | N | Normalized active-high outputs |

## Verification
The assertions assume that register accesses use word-aligned addresses and last exactly one cycle. They also assume that the raw lines are sampled only through the synchronizer, so any input timing is legal. The single-pulse properties take the code of a line as fixed over the two cycles they look at; the bench reprograms a line only while its input is quiet. The bench changes raw inputs and bus signals only on the falling clock edge, and it holds each input level for at least six cycles. This keeps every transition in a rising-edge or falling-edge mode separate, and lets every pulse count be checked against an exact cycle.

// File: rtl/wpn_pkg.sv
package wpn_pkg;

    localparam int REG_W     = 32;
    localparam int ENA_BASE  = 32'h10;
    localparam int CFG_BASE  = 32'h110;
    localparam int CODE_W    = 3;

    typedef logic [CODE_W-1:0] trig_code_t;

    localparam trig_code_t TRIG_LVL_LO    = 3'b000;
    localparam trig_code_t TRIG_EDGE_FALL = 3'b010;
    localparam trig_code_t TRIG_LVL_HI    = 3'b100;
    localparam trig_code_t TRIG_EDGE_RISE = 3'b110;
    localparam trig_code_t TRIG_EDGE_BOTH = 3'b111;

    typedef struct packed {
        logic valid;      // code is one of the five defined ones
        logic edge_mode;  // edge detection rather than level
        logic low_true;   // active-low level or falling edge
        logic both;       // any transition counts
    } line_mode_t;

    function automatic line_mode_t decode_trig(input trig_code_t code);
        line_mode_t m;
        m = '0;
        case (code)
            TRIG_LVL_LO:    begin m.valid = 1'b1; m.low_true = 1'b1; end
            TRIG_LVL_HI:    begin m.valid = 1'b1; end
            TRIG_EDGE_FALL: begin m.valid = 1'b1; m.edge_mode = 1'b1; m.low_true = 1'b1; end
            TRIG_EDGE_RISE: begin m.valid = 1'b1; m.edge_mode = 1'b1; end
            TRIG_EDGE_BOTH: begin m.valid = 1'b1; m.edge_mode = 1'b1; m.both = 1'b1; end
            default:        m = '0;
        endcase
        return m;
    endfunction

    function automatic logic is_reserved(input trig_code_t code);
        return !decode_trig(code).valid;
    endfunction

    // Next value of a normalized output from the synchronized sample and the
    // previous synchronized sample.
    function automatic logic normalize(input line_mode_t m, input logic en,
                                       input logic cur, input logic prev);
        logic r;
        if (!(en && m.valid))
            r = 1'b0;
        else if (!m.edge_mode)
            r = cur ^ m.low_true;
        else if (m.both)
            r = cur ^ prev;
        else if (m.low_true)
            r = prev & ~cur;
        else
            r = cur & ~prev;
        return r;
    endfunction

endpackage

// File: rtl/wpn_sync.sv
module wpn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wpn_line.sv
module wpn_line
    import wpn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    input  logic       en,
    input  trig_code_t code,
    output logic       out
);
    logic       cur;
    logic       prev;
    logic       out_q;
    line_mode_t mode;

    wpn_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (cur)
    );

    always_comb mode = decode_trig(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            out_q <= 1'b0;
        end else begin
            prev  <= cur;   // history tracks the input even when disabled
            out_q <= normalize(mode, en, cur, prev);
        end
    end

    assign out = out_q;
endmodule

// File: rtl/wpn_regs.sv
module wpn_regs
    import wpn_pkg::*;
#(
    parameter int N      = 168,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [REG_W-1:0]          bus_wdata,
    output logic [REG_W-1:0]          bus_rdata,
    output logic [N-1:0]              en_vec,
    output logic [N-1:0][CODE_W-1:0]  cfg_vec
);
    localparam int WA_W     = ADDR_W - 2;
    localparam int EN_WORDS = (N + REG_W - 1) / REG_W;
    localparam logic [WA_W-1:0] ENA_WORD  = WA_W'(ENA_BASE / 4);
    localparam logic [WA_W-1:0] CFG_WORD  = WA_W'(CFG_BASE / 4);
    localparam logic [WA_W-1:0] EN_CNT_W  = WA_W'(EN_WORDS);
    localparam logic [WA_W-1:0] CFG_CNT_W = WA_W'(N);

    logic [WA_W-1:0]  word_addr;
    logic             aligned;
    logic [WA_W-1:0]  ena_off;
    logic [WA_W-1:0]  cfg_off;
    logic             hit_ena;
    logic             hit_cfg;
    logic             wr_ena;
    logic             wr_cfg;
    logic             rd_req;
    logic [REG_W-1:0] rd_next;

    assign word_addr = bus_addr[ADDR_W-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign ena_off   = word_addr - ENA_WORD;
    assign cfg_off   = word_addr - CFG_WORD;
    assign hit_ena   = aligned && (word_addr >= ENA_WORD) && (ena_off < EN_CNT_W);
    assign hit_cfg   = aligned && (word_addr >= CFG_WORD) && (cfg_off < CFG_CNT_W);
    assign wr_ena    = bus_sel && bus_we && hit_ena;
    assign wr_cfg    = bus_sel && bus_we && hit_cfg;
    assign rd_req    = bus_sel && !bus_we;

    for (genvar i = 0; i < N; i++) begin : g_line_reg
        localparam int WORD = i / REG_W;
        localparam int BITP = i % REG_W;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_vec[i]  <= 1'b0;
                cfg_vec[i] <= TRIG_LVL_LO;
            end else begin
                if (wr_ena && (ena_off == WA_W'(WORD)))
                    en_vec[i] <= bus_wdata[BITP];
                if (wr_cfg && (cfg_off == WA_W'(i)))
                    cfg_vec[i] <= bus_wdata[CODE_W-1:0];
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (hit_ena) begin
            for (int i = 0; i < N; i++) begin
                if (ena_off == WA_W'(i / REG_W))
                    rd_next[i % REG_W] = en_vec[i];
            end
        end else if (hit_cfg) begin
            for (int i = 0; i < N; i++) begin
                if (cfg_off == WA_W'(i))
                    rd_next[CODE_W-1:0] = cfg_vec[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd_req)
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm
    import wpn_pkg::*;
#(
    parameter int N      = 168,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N-1:0]      irq_raw,
    output logic [N-1:0]      irq_out
);
    logic [N-1:0]             en_vec;
    logic [N-1:0][CODE_W-1:0] cfg_vec;

    wpn_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_vec    (en_vec),
        .cfg_vec   (cfg_vec)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        wpn_line u_line (
            .clk  (clk),
            .rst  (rst),
            .raw  (irq_raw[i]),
            .en   (en_vec[i]),
            .code (cfg_vec[i]),
            .out  (irq_out[i])
        );
    end
endmodule

// File: rtl/wake_polarity_norm_chk.sv
module wake_polarity_norm_chk
    import wpn_pkg::*;
#(
    parameter int N      = 168,
    parameter int ADDR_W = 12
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_sel,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [31:0]              bus_rdata,
    input logic [N-1:0]             irq_out,
    input logic [N-1:0]             en_vec,
    input logic [N-1:0][CODE_W-1:0] cfg_vec
);
    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 4 * N);

    logic cfg_read;
    assign cfg_read = bus_sel && !bus_we && (bus_addr >= CFG_LO) && (bus_addr < CFG_HI);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0 && bus_rdata == '0));

    assert_cfg_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_read) |-> (bus_rdata[31:3] == '0));

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_disabled_low_R9: assert property (@(posedge clk) disable iff (rst)
            !$past(en_vec[i]) |-> !irq_out[i]);

        assert_reserved_low_R11: assert property (@(posedge clk) disable iff (rst)
            is_reserved($past(cfg_vec[i])) |-> !irq_out[i]);

        assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst)
            (irq_out[i] && cfg_vec[i] == TRIG_EDGE_RISE && $past(cfg_vec[i]) == TRIG_EDGE_RISE)
            |=> !irq_out[i]);

        assert_fall_single_R7: assert property (@(posedge clk) disable iff (rst)
            (irq_out[i] && cfg_vec[i] == TRIG_EDGE_FALL && $past(cfg_vec[i]) == TRIG_EDGE_FALL)
            |=> !irq_out[i]);
    end
endmodule

bind wake_polarity_norm wake_polarity_norm_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_vec    (en_vec),
    .cfg_vec   (cfg_vec)
);

// File: tb/wake_polarity_norm_tb.sv
`timescale 1ns/1ps
module wake_polarity_norm_tb;
    localparam int N      = 168;
    localparam int ADDR_W = 12;
    localparam int WATCHDOG_NS = 400000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N-1:0]      irq_raw = '0;
    logic [N-1:0]      irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wake_polarity_norm #(.N(N), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_raw   (irq_raw),
        .irq_out   (irq_out)
    );

    function automatic logic [ADDR_W-1:0] ena_addr(input int line);
        return ADDR_W'(32'h10 + 4 * (line / 32));
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_addr(input int line);
        return ADDR_W'(32'h110 + 4 * line);
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_enable(input int line, input bit on);
        logic [31:0] w;
        bus_read(ena_addr(line), w);
        w[line % 32] = on;
        bus_write(ena_addr(line), w);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Change one raw line (at a falling edge) and watch its output for six cycles.
    task automatic drive_observe(input string req, input int line, input bit val,
                                 input int exp_first, input int exp_count);
        int first = 0;
        int count = 0;
        irq_raw[line] = val;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq_out[line]) begin
                count++;
                if (first == 0) first = k;
            end
        end
        check(req, $sformatf("line %0d first high cycle", line), first, exp_first);
        check(req, $sformatf("line %0d high cycles", line), count, exp_count);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        check("R1", "outputs after reset", irq_out, 0);
        check("R1", "rdata after reset", bus_rdata, 0);
        bus_read(ena_addr(0), d);   check("R1", "enable word0", d, 0);
        bus_read(ena_addr(167), d); check("R1", "enable word5", d, 0);
        bus_read(cfg_addr(0), d);   check("R1", "cfg line0", d, 0);
        bus_read(cfg_addr(99), d);  check("R1", "cfg line99", d, 0);
    endtask

    task automatic test_enable_bank();
        logic [31:0] d;
        set_enable(5, 1'b1);
        set_enable(0, 1'b1);
        bus_read(ena_addr(0), d);  check("R2", "word0 after set 5,0", d, 32'h21);
        set_enable(40, 1'b1);
        bus_read(ena_addr(40), d); check("R2", "word1 bit8", d, 32'h100);
        set_enable(5, 1'b0);
        bus_read(ena_addr(0), d);  check("R2", "word0 after clear 5", d, 32'h1);
        bus_read(ena_addr(40), d); check("R2", "word1 untouched", d, 32'h100);
        bus_write(ena_addr(160), 32'hFFFF_FFFF);
        bus_read(ena_addr(160), d); check("R2", "last word unused bits zero", d, 32'hFF);
        bus_write(ena_addr(160), 32'h0);
        bus_write(ena_addr(0), 32'h0);
        bus_write(ena_addr(40), 32'h0);
        bus_read(ena_addr(0), d);  check("R2", "word0 cleared", d, 0);
    endtask

    task automatic test_cfg_regs();
        logic [31:0] d;
        bus_write(cfg_addr(167), 32'hFFFF_FFFE);
        bus_read(cfg_addr(167), d); check("R3", "cfg167 readback code only", d, 32'h6);
        bus_read(cfg_addr(166), d); check("R3", "cfg166 untouched", d, 0);
        bus_write(cfg_addr(167), 32'h0);
    endtask

    task automatic test_level_high();
        bus_write(cfg_addr(32), 32'h4);
        set_enable(32, 1'b1);
        idle(4);
        check("R4", "level-high idle low", irq_out[32], 0);
        drive_observe("R4", 32, 1'b1, 3, 4);
        drive_observe("R4", 32, 1'b0, 1, 2);
    endtask

    task automatic test_level_low();
        bus_write(cfg_addr(1), 32'h0);
        set_enable(1, 1'b1);
        idle(4);
        check("R5", "active-low idle high", irq_out[1], 1);
        drive_observe("R5", 1, 1'b1, 1, 2);
        drive_observe("R5", 1, 1'b0, 3, 4);
    endtask

    task automatic test_rise();
        bus_write(cfg_addr(2), 32'h6);
        set_enable(2, 1'b1);
        idle(4);
        drive_observe("R6", 2, 1'b1, 3, 1);
        drive_observe("R6", 2, 1'b0, 0, 0);
    endtask

    task automatic test_fall();
        bus_write(cfg_addr(3), 32'h2);
        set_enable(3, 1'b1);
        idle(4);
        drive_observe("R7", 3, 1'b1, 0, 0);
        drive_observe("R7", 3, 1'b0, 3, 1);
    endtask

    task automatic test_both();
        bus_write(cfg_addr(4), 32'h7);
        set_enable(4, 1'b1);
        idle(4);
        drive_observe("R8", 4, 1'b1, 3, 1);
        drive_observe("R8", 4, 1'b0, 3, 1);
        check("R8", "neighbour line 3 quiet", irq_out[3], 0);
    endtask

    task automatic test_disabled();
        bus_write(cfg_addr(6), 32'h6);
        drive_observe("R9", 6, 1'b1, 0, 0);
        bus_write(cfg_addr(7), 32'h4);
        set_enable(7, 1'b1);
        irq_raw[7] = 1'b1;
        idle(6);
        check("R9", "level line high when enabled", irq_out[7], 1);
        set_enable(7, 1'b0);
        idle(2);
        check("R9", "level line low after disable", irq_out[7], 0);
        irq_raw[7] = 1'b0;
    endtask

    task automatic test_no_false_event();
        bus_write(cfg_addr(8), 32'h6);
        irq_raw[8] = 1'b1;
        idle(6);
        set_enable(8, 1'b1);
        drive_observe("R10", 8, 1'b1, 0, 0);
        bus_write(cfg_addr(9), 32'h2);
        set_enable(9, 1'b1);
        drive_observe("R10", 9, 1'b0, 0, 0);
    endtask

    task automatic test_reserved();
        logic [31:0] d;
        bus_write(cfg_addr(10), 32'h5);
        set_enable(10, 1'b1);
        drive_observe("R11", 10, 1'b1, 0, 0);
        drive_observe("R11", 10, 1'b0, 0, 0);
        bus_read(cfg_addr(10), d); check("R11", "code 101 readback", d, 32'h5);
        bus_write(cfg_addr(11), 32'h1);
        set_enable(11, 1'b1);
        drive_observe("R11", 11, 1'b1, 0, 0);
        bus_read(cfg_addr(11), d); check("R11", "code 001 readback", d, 32'h1);
        bus_write(cfg_addr(12), 32'h3);
        set_enable(12, 1'b1);
        drive_observe("R11", 12, 1'b1, 0, 0);
        bus_read(cfg_addr(12), d); check("R11", "code 011 readback", d, 32'h3);
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_enable_bank();
        test_cfg_regs();
        test_level_high();
        test_level_low();
        test_rise();
        test_fall();
        test_both();
        test_disabled();
        test_no_false_event();
        test_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule